// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector

This block picks one of several unrelated clock sources and passes it to a single output clock. A change of the select value never cuts a pulse short and never joins two pulses together. Each source owns a small lane: a two-stage synchroniser clocked by that source, and a gate-enable flop that updates on the source's falling edge. The output clock is the OR of all gated sources.

A switch happens in two steps. First the lane that is currently driving the output turns its enable off. The requested lane turns its enable on only after it has seen every other lane go quiet. Because of this, the switch takes a few cycles of each clock involved. A one-hot status vector, taken straight from the enable flops, shows which source is really on the output. It reads all-zero while a switch is in progress, so software can poll it until the new bit appears. With the source count set to one, the switching logic is left out: the output is the single source and the status is the constant 1.

Top module: `glitchfree_clk_mux`

## Requirements
- R1: While reset is held and just after it is released, the status is 1 (bit 0 set, no other bit set) and the output clock follows source 0.
- R2: The status never has more than one bit set.
- R3: When status bit i is set, the output clock equals source i. When the status is all-zero, the output clock is low.
- R4: After the select changes to a valid value v (0 to N-1) that is different from the current source, the status reads all-zero for a while and then shows only bit v. The bit position in the status equals the select value.
- R5: A lane's enable changes only while that lane's source clock is low, so every high or low phase of the output is at least as long as the shortest source half-period.
- R6: A select value of N or more (value 3 when N=3) leaves the current source on the output and the status unchanged.
- R7: If the select changes again before a switch has completed, the block settles on the most recent valid value.
- R8: Writing the select value of the source that is already driving the output causes no change to the status or the output.
- R9: When N=1 there is no switching logic: the output is source 0 and the status is the constant 1, whatever the select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | NUM_SRC | Source clocks, unrelated to each other; bit i is source i |
| rstN | input | 1 | Asynchronous reset, active low; after reset source 0 is selected |
| selIn | input | SEL_W | Requested source number; values of NUM_SRC or more are ignored |
| clkOut | output | 1 | Output clock |
| activeOh | output | NUM_SRC | One-hot status of the source driving clkOut; all-zero during a switch |

## Verification
On every edge of every source, the assertions check four things: the status is one-hot or zero, a set status bit agrees with a high output, an all-zero status agrees with a low output, and a lane's enable only moves while its own clock is low. They also check that an out-of-range select held steady keeps the current lane enabled. The following can only be shown by the bench's scenarios, with the sources running at unrelated periods: the all-zero window during a switch, the settling on the newest value when the select changes mid-switch, the minimum width of each output phase over a whole run, and the fact that the output really follows the source that the status names.

// File: rtl/gcm_pkg.sv
`timescale 1ns/10ps
package gcm_pkg;

  // Width of the select field for a given number of sources (never below one bit).
  function automatic int selWidthFor(input int nSrc);
    return (nSrc > 1) ? $clog2(nSrc) : 1;
  endfunction

endpackage

// File: rtl/gcm_lane.sv
`timescale 1ns/10ps
// One source lane: two-stage synchroniser in the source's own domain, then
// the gate enable applied on the falling edge so it moves only while low.
module gcm_lane #(
  parameter bit RST_ON = 1'b0
) (
  input  logic laneClk,
  input  logic rstN,
  input  logic want,
  input  logic othersBusy,
  output logic busy,
  output logic gateEn
);

  logic syncA;
  logic syncB;

  always_ff @(posedge laneClk or negedge rstN) begin
    if (!rstN) begin
      syncA <= RST_ON;
      syncB <= RST_ON;
    end else begin
      syncA <= want && !othersBusy;
      syncB <= syncA;
    end
  end

  always_ff @(negedge laneClk or negedge rstN) begin
    if (!rstN) gateEn <= RST_ON;
    else       gateEn <= syncB;
  end

  // A lane counts as busy while any stage still holds a request.
  assign busy = syncA | syncB | gateEn;

endmodule

// File: rtl/gcm_ctrl.sv
`timescale 1ns/10ps
// Control: decodes the select, holds on out-of-range values and interlocks
// the lanes so that a new lane starts only once all others are idle.
module gcm_ctrl #(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   selIn,
  output logic [NUM_SRC-1:0] gateEn
);

  localparam logic [SEL_W:0] SRC_LIMIT = (SEL_W + 1)'(NUM_SRC);

  logic               selValid;
  logic [NUM_SRC-1:0] laneBusy;
  logic [NUM_SRC-1:0] laneWant;
  logic [NUM_SRC-1:0] othersBusy;

  assign selValid = ({1'b0, selIn} < SRC_LIMIT);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    // Out-of-range select: each lane keeps asking for what it already drives.
    assign laneWant[i]   = selValid ? (selIn == SEL_W'(i)) : gateEn[i];
    assign othersBusy[i] = |(laneBusy & ~(NUM_SRC'(1) << i));

    gcm_lane #(
      .RST_ON (i == 0)
    ) u_lane (
      .laneClk    (srcClk[i]),
      .rstN       (rstN),
      .want       (laneWant[i]),
      .othersBusy (othersBusy[i]),
      .busy       (laneBusy[i]),
      .gateEn     (gateEn[i])
    );
  end

endmodule

// File: rtl/gcm_gate.sv
`timescale 1ns/10ps
// Datapath: AND each source with its enable, OR the results together.
module gcm_gate #(
  parameter int NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic [NUM_SRC-1:0] gateEn,
  output logic               clkOut
);

  assign clkOut = |(srcClk & gateEn);

endmodule

// File: rtl/glitchfree_clk_mux.sv
`timescale 1ns/10ps
module glitchfree_clk_mux
  import gcm_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = selWidthFor(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   selIn,
  output logic               clkOut,
  output logic [NUM_SRC-1:0] activeOh
);

  if (NUM_SRC == 1) begin : g_single
    // No choice to make: pass the clock through and report a constant status.
    logic unusedBits;
    assign unusedBits = ^{selIn, rstN};
    assign clkOut     = srcClk[0];
    assign activeOh   = 1'b1;
  end else begin : g_mux
    logic [NUM_SRC-1:0] gateEn;

    gcm_ctrl #(
      .NUM_SRC (NUM_SRC),
      .SEL_W   (SEL_W)
    ) u_ctrl (
      .srcClk (srcClk),
      .rstN   (rstN),
      .selIn  (selIn),
      .gateEn (gateEn)
    );

    gcm_gate #(
      .NUM_SRC (NUM_SRC)
    ) u_gate (
      .srcClk (srcClk),
      .gateEn (gateEn),
      .clkOut (clkOut)
    );

    // Status comes from the enables that are really gating the clocks.
    assign activeOh = gateEn;
  end

endmodule

// File: rtl/gcm_checker.sv
`timescale 1ns/10ps
module gcm_checker #(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2
) (
  input logic [NUM_SRC-1:0] srcClk,
  input logic               rstN,
  input logic [SEL_W-1:0]   selIn,
  input logic               clkOut,
  input logic [NUM_SRC-1:0] activeOh
);

  localparam logic [SEL_W:0] SRC_LIMIT = (SEL_W + 1)'(NUM_SRC);

  logic selValid;
  assign selValid = ({1'b0, selIn} < SRC_LIMIT);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R2
    status_onehot_chk: assert property (@(posedge srcClk[i]) disable iff (!rstN)
      $onehot0(activeOh));

    // R3
    high_follows_chk: assert property (@(negedge srcClk[i]) disable iff (!rstN)
      activeOh[i] |-> clkOut);

    // R3
    idle_low_chk: assert property (@(negedge srcClk[i]) disable iff (!rstN)
      (activeOh == '0) |-> !clkOut);

    // R6
    hold_invalid_chk: assert property (@(posedge srcClk[i]) disable iff (!rstN)
      (!selValid && $past(!selValid) && $past(!selValid, 2)
       && $past(activeOh[i]) && $past(activeOh[i], 2)) |-> activeOh[i]);

    // R5
    always @(activeOh[i]) begin
      if (rstN) begin
        en_moves_low_chk: assert (!srcClk[i]);
      end
    end
  end

endmodule

bind glitchfree_clk_mux gcm_checker #(
  .NUM_SRC (NUM_SRC),
  .SEL_W   (SEL_W)
) u_gcm_checker (.*);

// File: tb/glitchfree_clk_mux_bench.sv
`timescale 1ns/10ps
module glitchfree_clk_mux_bench;

  localparam int      NSRC  = 3;
  localparam int      SELW  = 2;
  localparam realtime HALF0 = 5.0;   // 100 MHz
  localparam realtime HALF1 = 7.3;
  localparam realtime HALF2 = 11.7;

  logic clk0 = 1'b0;
  logic clk1 = 1'b0;
  logic clk2 = 1'b0;
  logic rstN = 1'b0;
  logic [SELW-1:0] selIn = '0;
  logic selOne = 1'b0;

  wire [NSRC-1:0] srcVec = {clk2, clk1, clk0};
  wire            clkOut;
  wire [NSRC-1:0] activeOh;
  wire            clkOutOne;
  wire [0:0]      activeOne;

  glitchfree_clk_mux #(.NUM_SRC(NSRC)) u_glitchfree_clk_mux (
    .srcClk (srcVec), .rstN (rstN), .selIn (selIn),
    .clkOut (clkOut), .activeOh (activeOh)
  );

  glitchfree_clk_mux #(.NUM_SRC(1)) u_glitchfree_clk_mux_single (
    .srcClk (clk0), .rstN (rstN), .selIn (selOne),
    .clkOut (clkOutOne), .activeOh (activeOne)
  );

  initial forever #HALF0 clk0 = ~clk0;
  initial forever #HALF1 clk1 = ~clk1;
  initial forever #HALF2 clk2 = ~clk2;

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Phase-width and status monitors, running for the whole test.
  realtime lastEdge = 0.0;
  int      edgeSeen = 0;
  int      shortPhases = 0;
  int      badStatus = 0;

  always @(clkOut) begin
    if (edgeSeen > 0 && ($realtime - lastEdge) < HALF0 - 0.01) shortPhases++;
    lastEdge = $realtime;
    edgeSeen++;
  end

  always @(activeOh) begin
    if (rstN && !$onehot0(activeOh)) badStatus++;
  end

  task automatic waitEdge(input int k, input bit rise);
    case (k)
      0: if (rise) @(posedge clk0); else @(negedge clk0);
      1: if (rise) @(posedge clk1); else @(negedge clk1);
      default: if (rise) @(posedge clk2); else @(negedge clk2);
    endcase
  endtask

  function automatic logic observed(input bit single);
    return single ? clkOutOne : clkOut;
  endfunction

  task automatic followSrc(input int k, input bit single, input string req);
    int miss = 0;
    for (int r = 0; r < 4; r++) begin
      waitEdge(k, 1'b1);
      #0.5;
      if (observed(single) !== 1'b1) miss++;
      waitEdge(k, 1'b0);
      #0.5;
      if (observed(single) !== 1'b0) miss++;
    end
    check(miss == 0, req, "output follows named source, mismatches", miss, 0);
  endtask

  function automatic int ohIndex(input logic [NSRC-1:0] oh);
    for (int b = 0; b < NSRC; b++) if (oh[b]) return b;
    return 0;
  endfunction

  task automatic waitStatus(input logic [NSRC-1:0] exp, output bit reached,
                            output bit sawZero);
    reached = 1'b0;
    sawZero = 1'b0;
    for (int t = 0; t < 3000 && !reached; t++) begin
      #1;
      if (activeOh == '0) sawZero = 1'b1;
      if (activeOh == exp) reached = 1'b1;
    end
  endtask

  task automatic watchStable(input logic [NSRC-1:0] exp, output int dev);
    dev = 0;
    for (int t = 0; t < 400; t++) begin
      #1;
      if (activeOh != exp) dev++;
    end
  endtask

  // Stimulus table: [4:3] select value, [2:0] expected status afterwards.
  typedef logic [4:0] step_t;
  localparam int    NSTEP = 8;
  localparam step_t STEPS [NSTEP] = '{
    5'b01_010, 5'b10_100, 5'b00_001, 5'b11_001,
    5'b10_100, 5'b10_100, 5'b01_010, 5'b11_010
  };

  initial begin : watchdog
    #1ms;
    checks++;
    fails++;
    $display("FAIL R4 watchdog expired actual=%0h expected=%0h", activeOh, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [NSRC-1:0] prevExp;
    bit reached;
    bit sawZero;
    int dev;

    // R1: status during reset
    #30;
    check(activeOh == 3'b001, "R1", "status in reset", activeOh, 3'b001);
    #3 rstN = 1'b1;
    #20;
    check(activeOh == 3'b001, "R1", "status after reset", activeOh, 3'b001);
    followSrc(0, 1'b0, "R1");

    prevExp = 3'b001;
    for (int n = 0; n < NSTEP; n++) begin
      logic [SELW-1:0] s;
      logic [NSRC-1:0] e;
      s = STEPS[n][4:3];
      e = STEPS[n][2:0];
      selIn = s;
      if (s == 2'd3) begin
        watchStable(prevExp, dev);
        check(dev == 0, "R6", "out-of-range select, status deviations", dev, 0);
      end else if (e == prevExp) begin
        watchStable(prevExp, dev);
        check(dev == 0, "R8", "reselect current source, status deviations", dev, 0);
      end else begin
        waitStatus(e, reached, sawZero);
        check(reached, "R4", "status after switch", activeOh, e);
        check(sawZero, "R4", "all-zero window seen", sawZero, 1);
      end
      followSrc(ohIndex(e), 1'b0, "R3");
      prevExp = e;
    end

    // R7: change again before the first switch completes (status now 010)
    selIn = 2'd0;
    #3 selIn = 2'd2;
    waitStatus(3'b100, reached, sawZero);
    check(reached, "R7", "settled on newest select (2)", activeOh, 3'b100);
    followSrc(2, 1'b0, "R7");
    selIn = 2'd0;
    #12 selIn = 2'd1;
    waitStatus(3'b010, reached, sawZero);
    check(reached, "R7", "settled on newest select (1)", activeOh, 3'b010);
    #300;
    check(activeOh == 3'b010, "R7", "status stays on newest", activeOh, 3'b010);
    followSrc(1, 1'b0, "R7");

    // R9: single-source variant
    check(activeOne == 1'b1, "R9", "single status", activeOne, 1);
    followSrc(0, 1'b1, "R9");
    selOne = 1'b1;
    #50;
    check(activeOne == 1'b1, "R9", "single status with select 1", activeOne, 1);
    followSrc(0, 1'b1, "R9");

    // R2 and R5 over the whole run
    check(badStatus == 0, "R2", "multi-hot status events", badStatus, 0);
    check(shortPhases == 0, "R5", "output phases shorter than min half-period",
          shortPhases, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule